// File: doc/BRIEF.md
# USB Full-Speed Frame Interval Timer

This block produces the 1 ms frame timing of a full-speed USB host. It counts a 12 MHz tick enable with a 14-bit down-counter. When the counter reaches zero it reloads from a programmable interval, which gives a frame of interval+1 ticks. At each reload it starts a new frame: it pulses a start-of-frame output, advances a 16-bit frame number, and copies an interval toggle bit into a remaining toggle bit, so software can tell when a new interval has taken effect. The frame number overflow pulse fires whenever the frame number's most significant bit changes.

A programmable periodic start value splits each frame into two windows. While the remaining count is at or above that value, control and bulk traffic have priority. Once the count drops below it, a flag shows that periodic lists have priority. Counting runs only while the host is in the operational state (`run_i`). In every other state the counter and the frame number hold their values.

Software reaches four 32-bit registers through a simple single-cycle bus. Writes take effect on the clock edge on which `bus_we_i` is high. Reads are combinational from `bus_addr_i`. Nothing carries a data stream, so no valid/ready handshake is used and the bus never applies back-pressure.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, the interval reads 11999 and the periodic start reads 10799. The remaining count, the remaining toggle, the frame number, `sof_o` and `fno_o` are all 0.
- R2: Address 0 holds the interval in bits [13:0], the largest packet size in bits [30:16] and the interval toggle in bit 31. Bits [15:14] read as 0. Address 3 holds the periodic start in bits [13:0], and its other bits read as 0. Both registers read back what was written.
- R3: Writes to address 1 (remaining) and address 2 (frame number) change nothing that can be read back.
- R4: While `run_i` is low, or while `tick_i` is low, the remaining count and the frame number hold, and `sof_o` stays low.
- R5: On a counting tick with a nonzero remaining count, the count drops by one.
- R6: On a counting tick with a zero remaining count, the count reloads from the interval and the remaining toggle takes the interval toggle. `sof_o` is high in the next cycle. With one tick per cycle, consecutive `sof_o` pulses are interval+1 cycles apart. Address 1 reads as toggle in bit 31 and the count in bits [13:0].
- R7: Each `sof_o` pulse goes with a frame number one higher than before, wrapping at 16 bits. Address 2 reads the frame number in bits [15:0].
- R8: `fno_o` pulses together with `sof_o` exactly when frame number bit 15 changes, which happens at the steps 0x7FFF to 0x8000 and 0xFFFF to 0x0000.
- R9: `periodic_pri_o` is high exactly when the remaining count is below the periodic start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 12 MHz bit-time enable, one cycle wide |
| run_i | input | 1 | Host is in the operational state |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| sof_o | output | 1 | Start-of-frame pulse |
| fno_o | output | 1 | Frame number overflow pulse |
| periodic_pri_o | output | 1 | Periodic lists currently have priority |

## Verification
The properties assume that `tick_i` and `run_i` are known in every cycle after reset, and that a counting step happens only when both are high in the same cycle. They also assume that an interval written in the same cycle as a reload is not yet used by that reload. The stimulus changes `tick_i`, `run_i` and the bus only on the falling clock edge. It shrinks the interval to 9, and later to 0, so that whole frames and both frame number overflows fit in a short run. The large reset default is checked only by reading it back.

// File: rtl/ufi_pkg.sv
package ufi_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned TOG_BIT = 31;
  localparam int unsigned MPS_LSB = 16;
  localparam int unsigned MPS_W   = 15;

  typedef enum logic [1:0] {
    REG_INTERVAL = 2'd0,
    REG_REMAIN   = 2'd1,
    REG_FRNUM    = 2'd2,
    REG_PSTART   = 2'd3
  } ufi_reg_e;
endpackage

// File: rtl/ufi_regs.sv
module ufi_regs
  import ufi_pkg::*;
#(
  parameter int unsigned IW           = 14,
  parameter int unsigned NW           = 16,
  parameter int unsigned DEF_INTERVAL = 11999,
  parameter int unsigned DEF_PSTART   = 10799
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [IW-1:0]    rem_cnt,
  input  logic             rem_tog,
  input  logic [NW-1:0]    frame_num,
  output logic [IW-1:0]    interval,
  output logic             int_tog,
  output logic [IW-1:0]    pstart,
  output logic [BUS_W-1:0] rdata
);
  localparam logic [IW-1:0] RST_INT = IW'(DEF_INTERVAL);
  localparam logic [IW-1:0] RST_PS  = IW'(DEF_PSTART);

  logic [MPS_W-1:0] max_pkt;
  ufi_reg_e         sel;

  assign sel = ufi_reg_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval <= RST_INT;
      int_tog  <= 1'b0;
      max_pkt  <= '0;
      pstart   <= RST_PS;
    end else if (we) begin
      if (sel == REG_INTERVAL) begin
        interval <= wdata[IW-1:0];
        max_pkt  <= wdata[MPS_LSB +: MPS_W];
        int_tog  <= wdata[TOG_BIT];
      end
      if (sel == REG_PSTART) begin
        pstart <= wdata[IW-1:0];
      end
    end
  end

  logic unused_bits;
  assign unused_bits = &{1'b0, wdata[MPS_LSB-1:IW]};

  always_comb begin
    rdata = '0;
    case (sel)
      REG_INTERVAL: begin
        rdata[IW-1:0]            = interval;
        rdata[MPS_LSB +: MPS_W]  = max_pkt;
        rdata[TOG_BIT]           = int_tog;
      end
      REG_REMAIN: begin
        rdata[IW-1:0]  = rem_cnt;
        rdata[TOG_BIT] = rem_tog;
      end
      REG_FRNUM:  rdata[NW-1:0] = frame_num;
      REG_PSTART: rdata[IW-1:0] = pstart;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ufi_down_cnt.sv
module ufi_down_cnt #(
  parameter int unsigned IW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [IW-1:0] interval,
  input  logic          int_tog,
  output logic [IW-1:0] rem_cnt,
  output logic          rem_tog,
  output logic          wrap
);
  localparam logic [IW-1:0] ONE = IW'(1);

  assign wrap = step && (rem_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_cnt <= '0;
      rem_tog <= 1'b0;
    end else if (step) begin
      if (rem_cnt == '0) begin
        rem_cnt <= interval;
        rem_tog <= int_tog;
      end else begin
        rem_cnt <= rem_cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/ufi_frame_cnt.sv
module ufi_frame_cnt #(
  parameter int unsigned NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  output logic [NW-1:0] frame_num,
  output logic          sof,
  output logic          fno
);
  localparam logic [NW-1:0] ONE = NW'(1);

  logic [NW-1:0] nxt_num;
  assign nxt_num = frame_num + ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_num <= '0;
      sof       <= 1'b0;
      fno       <= 1'b0;
    end else begin
      sof <= wrap;
      fno <= wrap && (nxt_num[NW-1] != frame_num[NW-1]);
      if (wrap) frame_num <= nxt_num;
    end
  end
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import ufi_pkg::*;
#(
  parameter int unsigned IW           = 14,
  parameter int unsigned NW           = 16,
  parameter int unsigned DEF_INTERVAL = 11999,
  parameter int unsigned DEF_PSTART   = 10799
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        run_i,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        sof_o,
  output logic        fno_o,
  output logic        periodic_pri_o
);
  logic [IW-1:0] interval;
  logic          int_tog;
  logic [IW-1:0] pstart;
  logic [IW-1:0] rem_cnt;
  logic          rem_tog;
  logic          wrap;
  logic [NW-1:0] frame_num;
  logic          step;

  assign step = tick_i && run_i;

  ufi_regs #(
    .IW(IW), .NW(NW), .DEF_INTERVAL(DEF_INTERVAL), .DEF_PSTART(DEF_PSTART)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .rem_cnt(rem_cnt), .rem_tog(rem_tog),
    .frame_num(frame_num), .interval(interval), .int_tog(int_tog),
    .pstart(pstart), .rdata(bus_rdata_o)
  );

  ufi_down_cnt #(.IW(IW)) u_down (
    .clk(clk), .rst_n(rst_n), .step(step), .interval(interval),
    .int_tog(int_tog), .rem_cnt(rem_cnt), .rem_tog(rem_tog), .wrap(wrap)
  );

  ufi_frame_cnt #(.NW(NW)) u_frame (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .frame_num(frame_num),
    .sof(sof_o), .fno(fno_o)
  );

  assign periodic_pri_o = (rem_cnt < pstart);
endmodule

// File: rtl/ufi_chk.sv
module ufi_chk #(
  parameter int unsigned IW = 14,
  parameter int unsigned NW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          run_i,
  input logic          sof_o,
  input logic          fno_o,
  input logic [IW-1:0] rem_cnt,
  input logic          rem_tog,
  input logic [NW-1:0] frame_num,
  input logic [IW-1:0] interval,
  input logic          int_tog
);
  localparam logic [IW-1:0] ONE_C = IW'(1);
  localparam logic [NW-1:0] ONE_N = NW'(1);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_i && tick_i) |=> $stable(rem_cnt) && $stable(frame_num) && !sof_o); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && rem_cnt != '0) |=> rem_cnt == $past(rem_cnt) - ONE_C); // R5
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && rem_cnt == '0) |=>
      rem_cnt == $past(interval) && rem_tog == $past(int_tog) && sof_o); // R6
  AST_SOF_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> $past(run_i && tick_i)); // R6
  AST_FN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> frame_num == $past(frame_num) + ONE_N); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fno_o |-> sof_o && (frame_num[NW-1] != $past(frame_num[NW-1]))); // R8
endmodule

bind usb_frame_timer ufi_chk #(.IW(IW), .NW(NW)) u_chk (.*);

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        run_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = 2'd0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        sof_o, fno_o, periodic_pri_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int sof_cnt = 0;
  int fno_cnt = 0;
  int last_sof = 0;
  bit have_last = 0;
  bit mon_en = 0;
  bit done = 0;
  int exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  usb_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .sof_o(sof_o), .fno_o(fno_o),
    .periodic_pri_o(periodic_pri_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1;
    d = bus_rdata_o;
  endtask

  task automatic push_frames(input int n, input int gap);
    for (int i = 0; i < n; i++) exp_q.push_back(gap);
  endtask

  // scoreboard monitor: frame period between SOF pulses
  always @(negedge clk) begin
    if (sof_o) begin
      sof_cnt++;
      if (mon_en) begin
        if (have_last) begin
          if (exp_q.size() == 0) chk("R6 unexpected frame", 32'(cyc - last_sof), 32'hFFFF_FFFF);
          else chk("R6 frame period", 32'(cyc - last_sof), 32'(exp_q.pop_front()));
        end
        have_last = 1;
        last_sof = cyc;
      end
    end
    if (fno_o) fno_cnt++;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r1;
    int sof_before;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd0, d); chk("R1 interval", d, 32'd11999);
    bus_rd(2'd1, d); chk("R1 remaining", d, 32'd0);
    bus_rd(2'd2, d); chk("R1 frame number", d, 32'd0);
    bus_rd(2'd3, d); chk("R1 periodic start", d, 32'd10799);
    chk("R1 sof/fno low", {30'd0, sof_o, fno_o}, 32'd0);
    chk("R9 flag after reset", {31'd0, periodic_pri_o}, 32'd1);

    // R2 register fields
    bus_wr(2'd0, {1'b1, 15'h1234, 2'b11, 14'd9});
    bus_rd(2'd0, d); chk("R2 interval fields", d, {1'b1, 15'h1234, 2'b00, 14'd9});
    bus_wr(2'd3, 32'hFFFF_0005);
    bus_rd(2'd3, d); chk("R2 periodic start", d, 32'd5);

    // R3 read-only registers ignore writes
    bus_wr(2'd1, 32'hFFFF_FFFF);
    bus_rd(2'd1, d); chk("R3 remaining write ignored", d, 32'd0);
    bus_wr(2'd2, 32'h0000_1234);
    bus_rd(2'd2, d); chk("R3 frame number write ignored", d, 32'd0);

    // R4 no tick, or not running
    @(negedge clk); run_i = 1'b1; tick_i = 1'b0;
    repeat (5) @(negedge clk);
    run_i = 1'b0; tick_i = 1'b1;
    repeat (5) @(negedge clk);
    tick_i = 1'b0;
    bus_rd(2'd1, d); chk("R4 remaining held", d, 32'd0);
    chk("R4 no sof while idle", 32'(sof_cnt), 32'd0);

    // R5/R6/R7 frames of interval+1 ticks
    mon_en = 1; have_last = 0;
    push_frames(4, 10);
    @(negedge clk); run_i = 1'b1; tick_i = 1'b1;
    repeat (45) @(negedge clk);
    run_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 all frames seen", 32'(exp_q.size()), 32'd0);
    chk("R6 sof count", 32'(sof_cnt), 32'd5);
    bus_rd(2'd2, d); chk("R7 frame number", d, 32'd5);
    bus_rd(2'd1, d); chk("R5 R6 remaining and toggle", d, 32'h8000_0005);
    chk("R9 flag at start value", {31'd0, periodic_pri_o}, 32'd0);

    // R6 toggle follows a new interval toggle at reload
    bus_wr(2'd0, {1'b0, 15'h1234, 2'b00, 14'd9});
    mon_en = 0;
    @(negedge clk); run_i = 1'b1;
    repeat (6) @(negedge clk);
    run_i = 1'b0;
    bus_rd(2'd1, d); chk("R6 reload toggle cleared", d, 32'd9);
    chk("R6 sof after reload", 32'(sof_cnt), 32'd6);
    chk("R9 flag above start", {31'd0, periodic_pri_o}, 32'd0);

    // R9 sweep across the frame
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); run_i = 1'b1;
      @(negedge clk); run_i = 1'b0;
      bus_rd(2'd1, d);
      chk("R9 periodic flag", {31'd0, periodic_pri_o}, {31'd0, (d[13:0] < 14'd5)});
    end

    // R4 hold while stopped with ticks present
    bus_rd(2'd1, r1);
    sof_before = sof_cnt;
    repeat (10) @(negedge clk);
    bus_rd(2'd1, d); chk("R4 remaining stable", d, r1);
    chk("R4 no sof while stopped", 32'(sof_cnt), 32'(sof_before));

    // R8 overflow at both bit-15 transitions, one frame per tick
    bus_wr(2'd0, 32'd0);
    @(negedge clk); bus_addr_i = 2'd2; run_i = 1'b1;
    while (!fno_o) @(negedge clk);
    #1; chk("R8 first overflow", bus_rdata_o, 32'h0000_8000);
    @(negedge clk);
    while (!fno_o) @(negedge clk);
    #1; chk("R7 R8 wrap overflow", bus_rdata_o, 32'h0000_0000);
    run_i = 1'b0; tick_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 overflow count", 32'(fno_cnt), 32'd2);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule